// File: doc/BRIEF.md
# Event-Driven Timer/Counter with PWM Output

This block is a counter core steered by five single-cycle event inputs: reload, start, stop, count and capture. The counter counts up, down or up/down (triangle) within a period, and it only advances when a count event arrives while it is running. Before it reaches this block, every event has already been synchronized and edge- or level-qualified, so each input counts as one event for each cycle it is high.

There are two operating modes. In timer mode a capture event stores the count in a capture register and moves the previous capture value into a second, buffered capture register. In PWM mode the block drives a complementary output pair by comparing the count against an active compare value. In this mode the stop event becomes a kill that silences both outputs. The capture event becomes a switch that exchanges the active period and compare values with their buffered copies. The four configuration values are loaded from ports with a write strobe.

Top module: `evt_timer_pwm`

## Requirements
- R1: After reset the count, both capture registers, the active period and the active compare value are 0, and the counter is neither running nor killed.
- R2: A high `cfg_wr` loads the active period, buffered period, active compare and buffered compare from their inputs on the next edge. In the same cycle it overrides a switch.
- R3: Reload sets the count to 0 when `dir_sel` is 0 (up) or 2 (up/down, first moving upward), and to the active period when `dir_sel` is 1 (down). It also sets the counter running and clears a kill.
- R4: Start sets the counter running, leaves the count unchanged and clears a kill.
- R5: Stop halts the counter. While halted, count events leave the count unchanged.
- R6: In up mode each count event adds 1, and a count at or above the period wraps to 0.
- R7: In down mode each count event subtracts 1, and a count of 0 wraps to the period.
- R8: In up/down mode the count rises to the period, then falls to 0, then rises again. Each endpoint is visited once per turn (P=4: 0,1,2,3,4,3,2,1,0,1).
- R9: When several events are high in one cycle, only the highest-priority one takes effect, in the order reload, stop, start, capture, count. The others are discarded.
- R10: In timer mode a capture event loads the capture register with the count and the buffered capture register with the old capture value, on the same edge.
- R11: In PWM mode, when not killed, `pwm_o` is high exactly while count < compare and `pwm_n_o` is its complement. In timer mode both outputs are low.
- R12: In PWM mode a stop sets the kill state. Both outputs then stay low until a start or a reload.
- R13: In PWM mode a capture event swaps the active period and compare values with their buffered copies, visible from the next cycle. The capture registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_mode | input | 1 | 0 timer mode, 1 PWM mode |
| dir_sel | input | 2 | 0 up, 1 down, 2 up/down (3 acts as up) |
| cfg_wr | input | 1 | Load the four configuration values |
| period_in | input | W | Active period value to load |
| period_buf_in | input | W | Buffered period value to load |
| compare_in | input | W | Active compare value to load |
| compare_buf_in | input | W | Buffered compare value to load |
| ev_reload | input | 1 | Reload event |
| ev_start | input | 1 | Start event |
| ev_stop | input | 1 | Stop / kill event |
| ev_count | input | 1 | Count event |
| ev_capture | input | 1 | Capture / switch event |
| count_o | output | W | Current count |
| running_o | output | 1 | Counter running |
| killed_o | output | 1 | PWM outputs forced low |
| capture_o | output | W | Capture register |
| capture_buf_o | output | W | Buffered capture register |
| period_o | output | W | Active period |
| compare_o | output | W | Active compare value |
| pwm_o | output | 1 | PWM output |
| pwm_n_o | output | 1 | Complementary PWM output |

## Verification
Any error in the count, run flag, direction phase or kill flag shows up on `count_o`, `running_o`, `killed_o` or the PWM pair within one cycle of the event that caused it. The exception is a wrong up/down phase, which only surfaces at the next endpoint, after at most a period's worth of count events. A wrong swap or capture shift shows up on the value ports on the next edge. A misordered priority shows up as the wrong one of those effects on the edge where events collide. The directed scenarios therefore sample every port one cycle after each event and walk each counting direction across both wrap points.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  typedef enum logic [1:0] {
    CNT_UP   = 2'd0,
    CNT_DOWN = 2'd1,
    CNT_UPDN = 2'd2
  } cnt_dir_e;

  // Index of each event in the event vector; higher index wins.
  localparam int EV_NUM     = 5;
  localparam int EV_COUNT   = 0;
  localparam int EV_CAPTURE = 1;
  localparam int EV_START   = 2;
  localparam int EV_STOP    = 3;
  localparam int EV_RELOAD  = 4;
endpackage

// File: rtl/evt_prio_arb.sv
module evt_prio_arb
  import evt_tmr_pkg::*;
(
  input  logic [EV_NUM-1:0] ev_raw,
  output logic [EV_NUM-1:0] grant
);
  // Only the highest set event survives.
  for (genvar i = 0; i < EV_NUM; i++) begin : g_slot
    if (i == EV_NUM - 1) begin : g_top
      assign grant[i] = ev_raw[i];
    end else begin : g_low
      assign grant[i] = ev_raw[i] & ~(|ev_raw[EV_NUM-1:i+1]);
    end
  end
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        dir_sel,
  input  logic [W-1:0]      period,
  input  logic [EV_NUM-1:0] grant,
  output logic [W-1:0]      count,
  output logic              running,
  output logic              phase_down
);
  // Returns {next phase, next count} for one count event.
  function automatic logic [W:0] step(input logic [W-1:0] c, input logic [W-1:0] p,
                                      input cnt_dir_e d, input logic dn);
    logic [W-1:0] nc;
    logic         nd;
    nd = dn;
    case (d)
      CNT_DOWN: nc = (c == '0) ? p : c - W'(1);
      CNT_UPDN: begin
        if (!dn) begin
          if (c >= p) begin
            nd = 1'b1;
            nc = (c == '0) ? '0 : c - W'(1);
          end else begin
            nc = c + W'(1);
          end
        end else begin
          if (c == '0) begin
            nd = 1'b0;
            nc = (p == '0) ? '0 : W'(1);
          end else begin
            nc = c - W'(1);
          end
        end
      end
      default:  nc = (c >= p) ? '0 : c + W'(1);
    endcase
    return {nd, nc};
  endfunction

  cnt_dir_e   dir;
  logic [W:0] nxt;

  assign dir = cnt_dir_e'(dir_sel);
  assign nxt = step(count, period, dir, phase_down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      running    <= 1'b0;
      phase_down <= 1'b0;
    end else if (grant[EV_RELOAD]) begin
      count      <= (dir == CNT_DOWN) ? period : '0;
      running    <= 1'b1;
      phase_down <= 1'b0;
    end else if (grant[EV_STOP]) begin
      running <= 1'b0;
    end else if (grant[EV_START]) begin
      running <= 1'b1;
    end else if (grant[EV_COUNT] && running) begin
      count      <= nxt[W-1:0];
      phase_down <= nxt[W];
    end
  end
endmodule

// File: rtl/evt_capture_regs.sv
module evt_capture_regs
  import evt_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_mode,
  input  logic [EV_NUM-1:0] grant,
  input  logic [W-1:0]      count,
  output logic [W-1:0]      cap,
  output logic [W-1:0]      cap_buf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap     <= '0;
      cap_buf <= '0;
    end else if (grant[EV_CAPTURE] && !pwm_mode) begin
      cap     <= count;
      cap_buf <= cap;
    end
  end
endmodule

// File: rtl/evt_pwm_stage.sv
module evt_pwm_stage
  import evt_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_mode,
  input  logic              cfg_wr,
  input  logic [W-1:0]      period_in,
  input  logic [W-1:0]      period_buf_in,
  input  logic [W-1:0]      compare_in,
  input  logic [W-1:0]      compare_buf_in,
  input  logic [EV_NUM-1:0] grant,
  input  logic [W-1:0]      count,
  output logic [W-1:0]      period,
  output logic [W-1:0]      compare,
  output logic              killed,
  output logic              pwm,
  output logic              pwm_n
);
  logic [W-1:0] period_buf;
  logic [W-1:0] compare_buf;
  logic         swap_ev;
  logic         below;

  assign swap_ev = grant[EV_CAPTURE] && pwm_mode && !cfg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period      <= '0;
      period_buf  <= '0;
      compare     <= '0;
      compare_buf <= '0;
    end else if (cfg_wr) begin
      period      <= period_in;
      period_buf  <= period_buf_in;
      compare     <= compare_in;
      compare_buf <= compare_buf_in;
    end else if (swap_ev) begin
      period      <= period_buf;
      period_buf  <= period;
      compare     <= compare_buf;
      compare_buf <= compare;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      killed <= 1'b0;
    end else if (grant[EV_RELOAD] || grant[EV_START]) begin
      killed <= 1'b0;
    end else if (grant[EV_STOP] && pwm_mode) begin
      killed <= 1'b1;
    end
  end

  assign below = count < compare;
  assign pwm   = pwm_mode && !killed && below;
  assign pwm_n = pwm_mode && !killed && !below;
endmodule

// File: rtl/evt_timer_pwm.sv
module evt_timer_pwm
  import evt_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm_mode,
  input  logic [1:0]   dir_sel,
  input  logic         cfg_wr,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] period_buf_in,
  input  logic [W-1:0] compare_in,
  input  logic [W-1:0] compare_buf_in,
  input  logic         ev_reload,
  input  logic         ev_start,
  input  logic         ev_stop,
  input  logic         ev_count,
  input  logic         ev_capture,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         killed_o,
  output logic [W-1:0] capture_o,
  output logic [W-1:0] capture_buf_o,
  output logic [W-1:0] period_o,
  output logic [W-1:0] compare_o,
  output logic         pwm_o,
  output logic         pwm_n_o
);
  logic [EV_NUM-1:0] ev_raw;
  logic [EV_NUM-1:0] grant;
  logic              phase_down;

  always_comb begin
    ev_raw             = '0;
    ev_raw[EV_RELOAD]  = ev_reload;
    ev_raw[EV_STOP]    = ev_stop;
    ev_raw[EV_START]   = ev_start;
    ev_raw[EV_CAPTURE] = ev_capture;
    ev_raw[EV_COUNT]   = ev_count;
  end

  evt_prio_arb u_arb (.ev_raw(ev_raw), .grant(grant));

  evt_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel), .period(period_o),
    .grant(grant), .count(count_o), .running(running_o), .phase_down(phase_down)
  );

  evt_capture_regs #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .grant(grant),
    .count(count_o), .cap(capture_o), .cap_buf(capture_buf_o)
  );

  evt_pwm_stage #(.W(W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .cfg_wr(cfg_wr),
    .period_in(period_in), .period_buf_in(period_buf_in),
    .compare_in(compare_in), .compare_buf_in(compare_buf_in),
    .grant(grant), .count(count_o), .period(period_o), .compare(compare_o),
    .killed(killed_o), .pwm(pwm_o), .pwm_n(pwm_n_o)
  );
endmodule

// File: rtl/evt_timer_pwm_chk.sv
module evt_timer_pwm_chk
  import evt_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_mode,
  input logic [1:0]        dir_sel,
  input logic              cfg_wr,
  input logic [EV_NUM-1:0] grant,
  input logic [W-1:0]      count_o,
  input logic              running_o,
  input logic              killed_o,
  input logic [W-1:0]      capture_o,
  input logic [W-1:0]      capture_buf_o,
  input logic [W-1:0]      period_o,
  input logic              pwm_o,
  input logic              pwm_n_o
);
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_reload_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EV_RELOAD] |=> running_o && !killed_o &&
      (count_o == (($past(dir_sel) == 2'd1) ? $past(period_o) : '0)));

  assert_start_holds_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EV_START] |=> running_o && !killed_o && $stable(count_o));

  assert_stop_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EV_STOP] |=> !running_o);

  assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !grant[EV_RELOAD]) |=> $stable(count_o));

  assert_up_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[EV_COUNT] && running_o && dir_sel == 2'd0 && count_o >= period_o)
      |=> count_o == '0);

  assert_capture_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[EV_CAPTURE] && !pwm_mode) |=>
      capture_o == $past(count_o) && capture_buf_o == $past(capture_o));

  assert_pair_complement_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !killed_o) |-> (pwm_o != pwm_n_o));

  assert_kill_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    killed_o |-> (!pwm_o && !pwm_n_o));

  assert_switch_keeps_capture_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[EV_CAPTURE] && pwm_mode) |=> $stable(capture_o) && $stable(capture_buf_o));
endmodule

bind evt_timer_pwm evt_timer_pwm_chk #(.W(W)) u_chk (.*);

// File: tb/evt_timer_pwm_test.sv
module evt_timer_pwm_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwm_mode = 1'b0;
  logic [1:0]   dir_sel = 2'd0;
  logic         cfg_wr = 1'b0;
  logic [W-1:0] period_in = '0, period_buf_in = '0, compare_in = '0, compare_buf_in = '0;
  logic         ev_reload = 0, ev_start = 0, ev_stop = 0, ev_count = 0, ev_capture = 0;
  logic [W-1:0] count_o, capture_o, capture_buf_o, period_o, compare_o;
  logic         running_o, killed_o, pwm_o, pwm_n_o;

  int n_chk = 0;
  int n_bad = 0;

  evt_timer_pwm #(.W(W)) uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // e = {reload, stop, start, capture, count}; call and return at a falling edge.
  task automatic fire(input logic [4:0] e);
    {ev_reload, ev_stop, ev_start, ev_capture, ev_count} = e;
    @(negedge clk);
    {ev_reload, ev_stop, ev_start, ev_capture, ev_count} = '0;
  endtask

  task automatic cfg(input int p, input int pb, input int c, input int cb, input logic cap);
    period_in = W'(p); period_buf_in = W'(pb); compare_in = W'(c); compare_buf_in = W'(cb);
    cfg_wr = 1'b1; ev_capture = cap;
    @(negedge clk);
    cfg_wr = 1'b0; ev_capture = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "running", int'(running_o), 0);
    chk("R1", "capture", int'(capture_o), 0);
    chk("R1", "capture_buf", int'(capture_buf_o), 0);
    chk("R1", "period", int'(period_o), 0);
    chk("R1", "killed", int'(killed_o), 0);
    chk("R11", "timer pwm pair", int'({pwm_o, pwm_n_o}), 0);
  endtask

  task automatic t_cfg;
    cfg(4, 7, 2, 5, 1'b0);
    chk("R2", "period", int'(period_o), 4);
    chk("R2", "compare", int'(compare_o), 2);
  endtask

  task automatic t_up;
    int exp_seq[6] = '{1, 2, 3, 4, 0, 1};
    dir_sel = 2'd0;
    fire(5'b10000);
    chk("R3", "up reload count", int'(count_o), 0);
    chk("R3", "reload runs", int'(running_o), 1);
    foreach (exp_seq[i]) begin
      fire(5'b00001);
      chk("R6", "up step", int'(count_o), exp_seq[i]);
    end
  endtask

  task automatic t_stop;
    fire(5'b01000);
    chk("R5", "stopped", int'(running_o), 0);
    fire(5'b00001);
    chk("R5", "count ignored", int'(count_o), 1);
    fire(5'b00100);
    chk("R4", "start runs", int'(running_o), 1);
    chk("R4", "start keeps count", int'(count_o), 1);
    fire(5'b00001);
    chk("R6", "resumed", int'(count_o), 2);
  endtask

  task automatic t_down;
    int exp_seq[5] = '{3, 2, 1, 0, 4};
    dir_sel = 2'd1;
    fire(5'b10000);
    chk("R3", "down reload count", int'(count_o), 4);
    foreach (exp_seq[i]) begin
      fire(5'b00001);
      chk("R7", "down step", int'(count_o), exp_seq[i]);
    end
  endtask

  task automatic t_updn;
    int exp_seq[9] = '{1, 2, 3, 4, 3, 2, 1, 0, 1};
    dir_sel = 2'd2;
    fire(5'b10000);
    chk("R3", "updn reload count", int'(count_o), 0);
    foreach (exp_seq[i]) begin
      fire(5'b00001);
      chk("R8", "updn step", int'(count_o), exp_seq[i]);
    end
  endtask

  task automatic t_prio;
    dir_sel = 2'd0;
    fire(5'b00001); // count 1 -> 2 in up mode
    fire(5'b11000);
    chk("R9", "reload beats stop: count", int'(count_o), 0);
    chk("R9", "reload beats stop: running", int'(running_o), 1);
    fire(5'b00001);
    fire(5'b01100);
    chk("R9", "stop beats start", int'(running_o), 0);
    fire(5'b00111);
    chk("R9", "start beats capture/count: running", int'(running_o), 1);
    chk("R9", "start beats count: count", int'(count_o), 1);
    chk("R9", "start beats capture", int'(capture_o), 0);
    fire(5'b00011);
    chk("R9", "capture beats count: count", int'(count_o), 1);
    chk("R9", "capture beats count: capture", int'(capture_o), 1);
  endtask

  task automatic t_capture;
    fire(5'b00001);
    fire(5'b00001);
    fire(5'b00010);
    chk("R10", "capture", int'(capture_o), 3);
    chk("R10", "capture_buf", int'(capture_buf_o), 1);
    fire(5'b00001);
    fire(5'b00010);
    chk("R10", "capture again", int'(capture_o), 4);
    chk("R10", "buf takes old", int'(capture_buf_o), 3);
  endtask

  task automatic t_pwm;
    pwm_mode = 1'b1;
    fire(5'b10000);
    chk("R11", "pwm at 0", int'({pwm_o, pwm_n_o}), 2);
    fire(5'b00001);
    chk("R11", "pwm at 1", int'({pwm_o, pwm_n_o}), 2);
    fire(5'b00001);
    chk("R11", "pwm at 2", int'({pwm_o, pwm_n_o}), 1);
  endtask

  task automatic t_kill;
    fire(5'b01000);
    chk("R12", "killed", int'(killed_o), 1);
    chk("R12", "outputs off", int'({pwm_o, pwm_n_o}), 0);
    fire(5'b00001);
    chk("R12", "still off", int'({pwm_o, pwm_n_o}), 0);
    fire(5'b00100);
    chk("R12", "start clears kill", int'({pwm_o, pwm_n_o}), 1);
  endtask

  task automatic t_switch;
    fire(5'b00010);
    chk("R13", "period swapped", int'(period_o), 7);
    chk("R13", "compare swapped", int'(compare_o), 5);
    chk("R13", "capture untouched", int'(capture_o), 4);
    chk("R13", "new compare used", int'({pwm_o, pwm_n_o}), 2);
    fire(5'b00010);
    chk("R13", "period back", int'(period_o), 4);
    chk("R13", "compare back", int'(compare_o), 2);
    cfg(6, 9, 3, 1, 1'b1);
    chk("R2", "cfg beats switch: period", int'(period_o), 6);
    chk("R2", "cfg beats switch: compare", int'(compare_o), 3);
    fire(5'b01000);
    fire(5'b10000);
    chk("R12", "reload clears kill", int'(killed_o), 0);
    chk("R12", "reload outputs", int'({pwm_o, pwm_n_o}), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_up();
    t_stop();
    t_down();
    t_updn();
    t_prio();
    t_capture();
    t_pwm();
    t_kill();
    t_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule